// File: doc/BRIEF.md
# Fast Command Deserializer with Per-Command Delays

This block sits at the front end of a detector readout channel. Timing and control reaches it as a bank of serial lanes, each carrying two bits per bunch-crossing clock period, one on each clock edge. The block samples every lane on both edges, turns the bits into one 24-bit command word per crossing and splits that word into twelve command bits and a twelve-bit crossing identifier. Every command bit then passes through its own delay line. Each line has a separately programmable length, so every command lands on the crossing it refers to even though the link delivers all commands together and ahead of time.

The lanes run in one of two modes, chosen per crossing. In the packed mode, twelve lanes carry two distinct bits each. In the repeated mode, all 24 lanes carry one word bit each, and the bit is sent again on the second edge. A disagreement between the two halves in the repeated mode drops that crossing's commands and sets a flag that stays set. The crossing identifier goes through a fixed-length pipeline that matches the lead time of the link. Reset empties every pipeline, so no stale command can emerge after reset.

Top module: `fastcmd_deskew`

## Requirements
- R1: In the packed mode (`repeat_i`=0 at the rising edge), word bit 2k+1 is lane k sampled on the rising edge and word bit 2k is lane k sampled on the following falling edge, for k = 0..11. Word bits 23:12 are command bits 11:0 and word bits 11:0 are the crossing identifier.
- R2: In the packed mode, lanes 12..23 have no effect on any output.
- R3: In the repeated mode (`repeat_i`=1 at the rising edge), word bit k is lane k for k = 0..23 when the rising and falling samples of every lane agree.
- R4: In the repeated mode, if any lane differs between its rising and falling samples, all command bits of that crossing are suppressed and its crossing identifier is still delivered.
- R5: `err_o` rises one edge after the edge that follows a mismatching repeated-mode crossing. It stays high until reset and is never set by a packed-mode crossing.
- R6: With delay d for command i, `cmd_o[i]` carries that command bit of the word whose rising half was sampled d+1 clock edges earlier, for d = 0..31.
- R7: A write with `cfg_we_i`=1 sets the delay of command `cfg_addr_i` to `cfg_dly_i`, starting with the outputs that follow the write edge. Addresses 12..15 change nothing. Reset returns every delay to 0.
- R8: `bx_o` carries the crossing identifier of the word whose rising half was sampled BX_LAT+1 edges earlier (17 by default), with `bx_vld_o` high. Once high, `bx_vld_o` stays high until reset.
- R9: An edge with `rst` high clears every output and every pipeline. The first valid word is the one whose rising half is sampled on the first edge with `rst` low. Data sampled earlier never reaches an output.
- R10: `bx_o` is zero whenever `bx_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock; lanes are sampled on both edges |
| rst | input | 1 | Synchronous active-high reset |
| lane_i | input | 24 | Serial lane bits, two per clock period |
| repeat_i | input | 1 | Lane mode for the crossing whose rising half is sampled now: 0 packed, 1 repeated |
| cfg_we_i | input | 1 | Delay table write strobe |
| cfg_addr_i | input | 4 | Command index to write |
| cfg_dly_i | input | 5 | Delay in clock cycles, 0..31 |
| cmd_o | output | 12 | Delayed command strobes |
| bx_o | output | 12 | Crossing identifier of the current crossing |
| bx_vld_o | output | 1 | `bx_o` holds a valid identifier |
| err_o | output | 1 | Sticky repeated-half mismatch flag |

## Verification
A wrong bit position in the lane merge shows up within two edges on the zero-delay command outputs and on the identifier 17 edges later, as a swapped or displaced bit. A delay line that is off by one shows up one cycle early or late on the command it feeds. This appears as soon as a delay is programmed that selects that stage, so the sweep steps all 32 delay values across all twelve commands with pseudo-random words. A failed flush or a lost error flag shows up on the first edges after reset and after an injected mismatch.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int LANES      = 24;
    localparam int CMD_N      = 12;
    localparam int BX_W       = 12;
    localparam int WORD_W     = CMD_N + BX_W;
    localparam int HALF_W     = WORD_W / 2;
    localparam int DLY_W      = 5;
    localparam int CFG_AW     = $clog2(CMD_N);
    localparam int BX_LAT_DEF = 16;

    typedef struct packed {
        logic [CMD_N-1:0] cmd;
        logic [BX_W-1:0]  bx;
    } fc_word_t;

    typedef enum logic {
        MODE_PACKED = 1'b0,
        MODE_REPEAT = 1'b1
    } lane_mode_e;

    // Packed mode: rising sample is the odd bit, falling sample the even bit.
    function automatic logic [WORD_W-1:0] ddr_merge(
        input logic [LANES-1:0] r,
        input logic [LANES-1:0] f
    );
        logic [WORD_W-1:0] w;
        w = '0;
        for (int k = 0; k < HALF_W; k++) begin
            w[2*k+1] = r[k];
            w[2*k]   = f[k];
        end
        return w;
    endfunction

    // Repeated mode: one word bit per lane, taken from the rising sample.
    function automatic logic [WORD_W-1:0] rep_merge(input logic [LANES-1:0] r);
        return r[WORD_W-1:0];
    endfunction

    function automatic fc_word_t to_word(input logic [WORD_W-1:0] v);
        fc_word_t w;
        w.cmd = v[WORD_W-1 -: CMD_N];
        w.bx  = v[BX_W-1:0];
        return w;
    endfunction

endpackage

// File: rtl/fcd_ddr_capture.sv
module fcd_ddr_capture
    import fcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LANES-1:0]     lane_i,
    input  logic                 rep_i,
    output fc_word_t             word_o,
    output logic                 vld_o,
    output logic                 rep_o,
    output logic                 err_o
);

    logic [LANES-1:0] rise_q;
    logic [LANES-1:0] fall_q;
    lane_mode_e       mode_q;
    logic             rise_v;
    logic             mism;
    fc_word_t         word_n;

    // rising half and the mode that belongs to it
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= '0;
            mode_q <= MODE_PACKED;
            rise_v <= 1'b0;
        end else begin
            rise_q <= lane_i;
            mode_q <= lane_mode_e'(rep_i);
            rise_v <= 1'b1;
        end
    end

    // falling half
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= '0;
        end else begin
            fall_q <= lane_i;
        end
    end

    always_comb begin
        mism   = (mode_q == MODE_REPEAT) && (rise_q != fall_q);
        word_n = (mode_q == MODE_REPEAT) ? to_word(rep_merge(rise_q))
                                         : to_word(ddr_merge(rise_q, fall_q));
        if (mism) begin
            word_n.cmd = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            vld_o  <= 1'b0;
            rep_o  <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            word_o <= rise_v ? word_n : '0;
            vld_o  <= rise_v;
            rep_o  <= rise_v && (mode_q == MODE_REPEAT);
            err_o  <= err_o | (rise_v & mism);
        end
    end

endmodule

// File: rtl/fcd_delay_cfg.sv
module fcd_delay_cfg #(
    parameter int CMD_N = 12,
    parameter int DLY_W = 5,
    localparam int AW   = $clog2(CMD_N)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [DLY_W-1:0]            dly_i,
    output logic [CMD_N-1:0][DLY_W-1:0] dly_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_o <= '0;
        end else if (we_i && (32'(addr_i) < CMD_N)) begin
            dly_o[addr_i] <= dly_i;
        end
    end

endmodule

// File: rtl/fcd_tap_delay.sv
module fcd_tap_delay #(
    parameter int DLY_W  = 5,
    localparam int DEPTH = (1 << DLY_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             d_i,
    input  logic [DLY_W-1:0] sel_i,
    output logic             q_o
);

    logic [DEPTH:1] sh;
    logic [DEPTH:0] taps;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[DEPTH-1:1], d_i};
        end
    end

    assign taps = {sh, d_i};
    assign q_o  = taps[sel_i];

endmodule

// File: rtl/fcd_bx_pipe.sv
module fcd_bx_pipe #(
    parameter int BX_W = 12,
    parameter int LAT  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vld_i,
    input  logic [BX_W-1:0] bx_i,
    output logic            vld_o,
    output logic [BX_W-1:0] bx_o
);

    typedef struct packed {
        logic            vld;
        logic [BX_W-1:0] bx;
    } bx_stage_t;

    bx_stage_t stg [LAT];

    generate
        for (genvar s = 0; s < LAT; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stg[0] <= '0;
                    end else begin
                        stg[0].vld <= vld_i;
                        stg[0].bx  <= vld_i ? bx_i : '0;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stg[s] <= '0;
                    end else begin
                        stg[s] <= stg[s-1];
                    end
                end
            end
        end
    endgenerate

    assign vld_o = stg[LAT-1].vld;
    assign bx_o  = stg[LAT-1].bx;

endmodule

// File: rtl/fastcmd_deskew.sv
module fastcmd_deskew
    import fcd_pkg::*;
#(
    parameter int BX_LAT = BX_LAT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  lane_i,
    input  logic              repeat_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [DLY_W-1:0]  cfg_dly_i,
    output logic [CMD_N-1:0]  cmd_o,
    output logic [BX_W-1:0]   bx_o,
    output logic              bx_vld_o,
    output logic              err_o
);

    fc_word_t                   w_word;
    logic                       w_vld;
    logic                       w_rep;
    logic [CMD_N-1:0][DLY_W-1:0] dly_tab;

    fcd_ddr_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .lane_i (lane_i),
        .rep_i  (repeat_i),
        .word_o (w_word),
        .vld_o  (w_vld),
        .rep_o  (w_rep),
        .err_o  (err_o)
    );

    fcd_delay_cfg #(
        .CMD_N (CMD_N),
        .DLY_W (DLY_W)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we_i   (cfg_we_i),
        .addr_i (cfg_addr_i),
        .dly_i  (cfg_dly_i),
        .dly_o  (dly_tab)
    );

    generate
        for (genvar i = 0; i < CMD_N; i++) begin : g_cmd
            fcd_tap_delay #(
                .DLY_W (DLY_W)
            ) u_dly (
                .clk   (clk),
                .rst   (rst),
                .d_i   (w_word.cmd[i] & w_vld),
                .sel_i (dly_tab[i]),
                .q_o   (cmd_o[i])
            );
        end
    endgenerate

    fcd_bx_pipe #(
        .BX_W (BX_W),
        .LAT  (BX_LAT)
    ) u_bx (
        .clk   (clk),
        .rst   (rst),
        .vld_i (w_vld),
        .bx_i  (w_word.bx),
        .vld_o (bx_vld_o),
        .bx_o  (bx_o)
    );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CMD_N-1:0] cmd_o,
    input logic [BX_W-1:0]  bx_o,
    input logic             bx_vld_o,
    input logic             err_o,
    input logic             word_vld,
    input logic             word_rep
);

    logic rst_q = 1'b1;

    always @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) begin
            AST_FLUSHED: assert (cmd_o == '0 && !bx_vld_o && !err_o); // R9
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o); // R5

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (word_rep && word_vld)); // R5

    AST_BX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bx_vld_o |-> (bx_o == '0)); // R10

    AST_BX_HOLD: assert property (@(posedge clk) disable iff (rst)
        bx_vld_o |=> bx_vld_o); // R8

endmodule

bind fastcmd_deskew fcd_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_o    (cmd_o),
    .bx_o     (bx_o),
    .bx_vld_o (bx_vld_o),
    .err_o    (err_o),
    .word_vld (w_vld),
    .word_rep (w_rep)
);

// File: tb/fastcmd_deskew_test.sv
`timescale 1ns/1ps
module fastcmd_deskew_test;

    localparam int BXL  = 16;
    localparam int HMAX = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] lane_i = '0;
    logic        repeat_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [3:0]  cfg_addr_i = '0;
    logic [4:0]  cfg_dly_i = '0;
    logic [11:0] cmd_o;
    logic [11:0] bx_o;
    logic        bx_vld_o;
    logic        err_o;

    fastcmd_deskew #(.BX_LAT(BXL)) uut (
        .clk(clk), .rst(rst), .lane_i(lane_i), .repeat_i(repeat_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_dly_i(cfg_dly_i),
        .cmd_o(cmd_o), .bx_o(bx_o), .bx_vld_o(bx_vld_o), .err_o(err_o)
    );

    always #2 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [11:0] h_cmd [HMAX];
    logic [11:0] h_bx  [HMAX];
    bit          h_mm  [HMAX];
    int          dm    [12];
    int          c = -1;
    int          first_ok = 1;
    bit          err_m = 1'b0;
    logic [31:0] seed = 32'h1357_9bdf;

    bit          p_rst = 1'b1;
    bit          p_we = 1'b0;
    logic [3:0]  p_wa = '0;
    logic [4:0]  p_wd = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", req, c, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic tick(input logic [23:0] rv, input logic [23:0] fv, input logic rep,
                        input logic [11:0] ecmd, input logic [11:0] ebx, input bit mm,
                        input string tag);
        logic [11:0] e;
        int j;
        @(negedge clk);
        #1;
        lane_i = rv; repeat_i = rep; rst = p_rst;
        cfg_we_i = p_we; cfg_addr_i = p_wa; cfg_dly_i = p_wd;
        @(posedge clk);
        c++;
        h_cmd[c] = ecmd; h_bx[c] = ebx; h_mm[c] = mm;
        if (p_rst) begin
            first_ok = c + 1;
            err_m = 1'b0;
            for (int i = 0; i < 12; i++) dm[i] = 0;
        end else begin
            if (p_we && p_wa < 12) dm[p_wa] = int'(p_wd);
            if (c >= 1 && (c - 1) >= first_ok && h_mm[c-1]) err_m = 1'b1;
        end
        p_we = 1'b0;
        #1;
        lane_i = fv; cfg_we_i = 1'b0;
        for (int i = 0; i < 12; i++) begin
            j = c - 1 - dm[i];
            e[i] = (j >= 0 && j >= first_ok) ? h_cmd[j][i] : 1'b0;
        end
        check({tag, "/R6 cmd"}, 32'(cmd_o), 32'(e));
        j = c - 1 - BXL;
        check({tag, "/R8 bx_vld"}, 32'(bx_vld_o), 32'((j >= 0 && j >= first_ok) ? 1 : 0));
        check({tag, "/R10 bx"}, 32'(bx_o), (j >= 0 && j >= first_ok) ? 32'(h_bx[j]) : 32'd0);
        check({tag, "/R5 err"}, 32'(err_o), 32'(err_m));
    endtask

    task automatic send_packed(input logic [23:0] w, input logic [23:0] noise, input string tag);
        logic [23:0] rv, fv;
        for (int k = 0; k < 12; k++) begin
            rv[k] = w[2*k+1];
            fv[k] = w[2*k];
        end
        rv[23:12] = noise[11:0];
        fv[23:12] = noise[23:12];
        tick(rv, fv, 1'b0, w[23:12], w[11:0], 1'b0, tag);
    endtask

    task automatic send_rep(input logic [23:0] w, input logic [23:0] flip, input string tag);
        bit mm;
        mm = (flip != 0);
        tick(w, w ^ flip, 1'b1, mm ? 12'h000 : w[23:12], w[11:0], mm, tag);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) dm[i] = 0;
        // reset state
        p_rst = 1'b1;
        for (int n = 0; n < 3; n++) send_packed(24'hffffff, 24'hffffff, "R9");
        p_rst = 1'b0;

        // packed assembly with delays at reset value 0
        for (int n = 0; n < 60; n++) send_packed(rnd()[23:0], 24'h0, "R1");
        // ignored upper lanes: constant word, wild noise
        for (int n = 0; n < 40; n++) send_packed(24'h5a3c96 ^ 24'(n), rnd()[23:0], "R2");

        // delay sweep: every command, every delay value
        for (int d = 0; d < 32; d++) begin
            for (int i = 0; i < 12; i++) begin
                p_we = 1'b1; p_wa = 4'(i); p_wd = 5'((d + i * 7) % 32);
                send_packed(rnd()[23:0], rnd()[23:0], "R7");
            end
            for (int n = 0; n < 36; n++) send_packed(rnd()[23:0], rnd()[23:0], "R6");
        end

        // writes to unused addresses have no effect
        for (int a = 12; a < 16; a++) begin
            p_we = 1'b1; p_wa = 4'(a); p_wd = 5'd9;
            send_packed(rnd()[23:0], 24'h0, "R7");
        end
        for (int n = 0; n < 40; n++) send_packed(rnd()[23:0], 24'h0, "R7");

        // repeated mode, clean halves
        for (int n = 0; n < 80; n++) send_rep(rnd()[23:0], 24'h0, "R3");
        check("R5 err clean", 32'(err_o), 32'd0);

        // repeated mode with one mismatching crossing
        send_rep(24'hfff123, 24'h000400, "R4");
        for (int n = 0; n < 40; n++) send_rep(rnd()[23:0], 24'h0, "R4");
        check("R5 err set", 32'(err_o), 32'd1);
        for (int n = 0; n < 20; n++) send_packed(rnd()[23:0], 24'h0, "R5");
        check("R5 err held", 32'(err_o), 32'd1);

        // reset mid-stream flushes pipelines and delay table
        p_rst = 1'b1;
        for (int n = 0; n < 2; n++) send_packed(24'hffffff, 24'h0, "R9");
        p_rst = 1'b0;
        for (int n = 0; n < 40; n++) send_packed(rnd()[23:0], 24'h0, "R9");
        check("R9 err cleared", 32'(err_o), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule